// File: doc/BRIEF.md
# Byte Program Sequencer for a Parallel Flash Programming Port

This block sits on the programmer side of a parallel, byte-wide flash programming port. It takes address/data pairs from a valid/ready stream and, for each pair, walks the port through one byte write. It places the address and data on the pins, drives the write-code mode select lines, and raises the high-voltage enable. It then issues a single active-low program strobe and waits for the target to finish its self-timed write.

The completion check is chosen per byte. Either the target's ready/busy pin is watched until it returns high, or the last byte is read back until bit 7 matches the value written. A cycle counter bounds that wait and aborts the byte on expiry. An optional verify phase then switches to the read-code mode and compares the whole byte. Every byte ends with a one-cycle result pulse that carries an error flag, an error code and the failing address.

The host drives the data bus only while writing. In every read or poll phase the bus is released, and the target's data comes back on a separate input.

Top module: `byte_prog_seq`

## Requirements
- R1: Out of reset and whenever idle, in_ready is 1, prog_n is 1, vpp_en is 0, data_oe is 0 and byte_done is 0.
- R2: For each byte, prg_addr, data_out, data_oe and the write mode are in place for SETUP_CYC cycles before vpp_en rises. vpp_en is then high for SETUP_CYC cycles before prog_n falls.
- R3: prog_n goes low for exactly PULSE_CYC clock cycles, once per accepted pair.
- R4: mode_sel (bit 4 down to bit 0) carries the write-code value 5'b01111 from setup through hold, and the read-code value 5'b00011 in idle, polling and verify.
- R5: With cfg_use_poll=0, the write is complete only when rdy_busy is 1, sampled from SETTLE_CYC cycles after the hold phase onward. Read data has no effect on completion.
- R6: With cfg_use_poll=1, the write is complete when data_in[7] equals bit 7 of the written byte. rdy_busy has no effect on completion.
- R7: If completion is not seen within TIMEOUT_CYC cycles of the wait phase, the byte ends with byte_done and byte_err set, err_code=2'b01 and err_addr equal to the byte's address. The result comes exactly 2*SETUP_CYC+PULSE_CYC+HOLD_CYC+TIMEOUT_CYC cycles after the accepting edge, and verify is skipped.
- R8: With cfg_verify=1, after completion the full byte read in read-code mode is compared with the written data. A mismatch gives byte_err=1, err_code=2'b10 and err_addr equal to the address. A match gives byte_err=0.
- R9: data_oe is 1 only in the setup, raise, strobe and hold phases, and never while mode_sel holds the read-code value.
- R10: cfg_use_poll and cfg_verify are captured when a pair is accepted. A change while the byte is in progress has no effect on that byte.
- R11: in_ready is 0 from acceptance until the byte's result, byte_done pulses for exactly one cycle per accepted pair, and byte_err is never set without byte_done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Address/data pair offered |
| in_ready | output | 1 | Sequencer idle and able to take a pair |
| in_addr | input | AW | Byte address |
| in_data | input | 8 | Byte value to program |
| cfg_use_poll | input | 1 | 1: completion by bit-7 polling, 0: by ready/busy pin |
| cfg_verify | input | 1 | 1: read back and compare after completion |
| prg_addr | output | AW | Address presented to the target |
| data_out | output | 8 | Data driven toward the target |
| data_oe | output | 1 | Host drives the data bus when 1 |
| data_in | input | 8 | Data bus as read from the target |
| mode_sel | output | 5 | Mode select lines, write 5'b01111, read 5'b00011 |
| vpp_en | output | 1 | Program-enable high-voltage request |
| prog_n | output | 1 | Active-low program strobe |
| rdy_busy | input | 1 | Target status, 1 ready, 0 busy |
| byte_done | output | 1 | One-cycle pulse at the end of each byte |
| byte_err | output | 1 | With byte_done: the byte failed |
| err_code | output | 2 | Last result: 00 ok, 01 timeout, 10 verify mismatch |
| err_addr | output | AW | Address of the last failing byte |

## Verification
The bench targets three kinds of fault. The first is the choice of completion source: the pin is stuck busy while the data already polls good, and the data is forced good while the pin is still busy. A sequencer that mixed up the two sources would finish early, or would never finish. The second is the timeout: the bench counts its exact cycle position, so a counter that is off by one moves the result pulse and fails the check. The third covers a configuration change during a byte, a read-back that differs only in bit 0, and the order and width of the enable and strobe. Each of these would surface as a missed error, a wrong error code or a mistimed pin edge.

// File: rtl/byte_prog_seq.sv
module byte_prog_seq #(
  parameter int AW          = 15,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 26,
  parameter int HOLD_CYC    = 2,
  parameter int SETTLE_CYC  = 2,
  parameter int TIMEOUT_CYC = 7000
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [7:0]    in_data,
  input  logic          cfg_use_poll,
  input  logic          cfg_verify,
  output logic [AW-1:0] prg_addr,
  output logic [7:0]    data_out,
  output logic          data_oe,
  input  logic [7:0]    data_in,
  output logic [4:0]    mode_sel,
  output logic          vpp_en,
  output logic          prog_n,
  input  logic          rdy_busy,
  output logic          byte_done,
  output logic          byte_err,
  output logic [1:0]    err_code,
  output logic [AW-1:0] err_addr
);
  localparam int M1   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2   = (M1 > HOLD_CYC) ? M1 : HOLD_CYC;
  localparam int M3   = (M2 > SETTLE_CYC) ? M2 : SETTLE_CYC;
  localparam int MAXC = (M3 > TIMEOUT_CYC) ? M3 : TIMEOUT_CYC;
  localparam int CW   = $clog2(MAXC + 1) + 1;

  localparam logic [CW-1:0] SU_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] PW_LAST = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] HD_LAST = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] SETTLE  = CW'(SETTLE_CYC);

  localparam logic [4:0] MODE_WR = 5'b01111;
  localparam logic [4:0] MODE_RD = 5'b00011;
  localparam logic [1:0] E_NONE  = 2'b00;
  localparam logic [1:0] E_TMO   = 2'b01;
  localparam logic [1:0] E_MIS   = 2'b10;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_RAISE, S_STROBE, S_HOLD, S_WAIT, S_VERIFY
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [7:0]    d_q;
  logic          poll_q, vfy_q;
  logic          writing, complete;

  assign writing  = (st == S_SETUP) || (st == S_RAISE) || (st == S_STROBE) || (st == S_HOLD);
  assign complete = poll_q ? (data_in[7] == d_q[7]) : rdy_busy;

  assign in_ready = (st == S_IDLE);
  assign prg_addr = a_q;
  assign data_out = d_q;
  assign data_oe  = writing;
  assign vpp_en   = (st == S_RAISE) || (st == S_STROBE) || (st == S_HOLD) || (st == S_WAIT);
  assign prog_n   = (st != S_STROBE);
  assign mode_sel = (writing || (st == S_WAIT && !poll_q)) ? MODE_WR : MODE_RD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      a_q       <= '0;
      d_q       <= '0;
      poll_q    <= 1'b0;
      vfy_q     <= 1'b0;
      byte_done <= 1'b0;
      byte_err  <= 1'b0;
      err_code  <= E_NONE;
      err_addr  <= '0;
    end else begin
      byte_done <= 1'b0;
      byte_err  <= 1'b0;
      case (st)
        S_IDLE: if (in_valid) begin
          a_q    <= in_addr;
          d_q    <= in_data;
          poll_q <= cfg_use_poll;
          vfy_q  <= cfg_verify;
          cnt    <= '0;
          st     <= S_SETUP;
        end
        S_SETUP: begin
          cnt <= cnt + 1'b1;
          if (cnt == SU_LAST) begin cnt <= '0; st <= S_RAISE; end
        end
        S_RAISE: begin
          cnt <= cnt + 1'b1;
          if (cnt == SU_LAST) begin cnt <= '0; st <= S_STROBE; end
        end
        S_STROBE: begin
          cnt <= cnt + 1'b1;
          if (cnt == PW_LAST) begin cnt <= '0; st <= S_HOLD; end
        end
        S_HOLD: begin
          cnt <= cnt + 1'b1;
          if (cnt == HD_LAST) begin cnt <= '0; st <= S_WAIT; end
        end
        S_WAIT: begin
          cnt <= cnt + 1'b1;
          if (cnt >= SETTLE && complete) begin
            cnt <= '0;
            if (vfy_q) st <= S_VERIFY;
            else begin
              st        <= S_IDLE;
              byte_done <= 1'b1;
              err_code  <= E_NONE;
            end
          end else if (cnt == TO_LAST) begin
            st        <= S_IDLE;
            byte_done <= 1'b1;
            byte_err  <= 1'b1;
            err_code  <= E_TMO;
            err_addr  <= a_q;
          end
        end
        S_VERIFY: begin
          cnt <= cnt + 1'b1;
          if (cnt == SETTLE) begin
            st        <= S_IDLE;
            byte_done <= 1'b1;
            if (data_in != d_q) begin
              byte_err <= 1'b1;
              err_code <= E_MIS;
              err_addr <= a_q;
            end else begin
              err_code <= E_NONE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/byte_prog_seq_chk.sv
module byte_prog_seq_chk #(
  parameter int AW        = 15,
  parameter int PULSE_CYC = 26
)(
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          prog_n,
  input logic          vpp_en,
  input logic          data_oe,
  input logic [4:0]    mode_sel,
  input logic [AW-1:0] prg_addr,
  input logic          byte_done,
  input logic          byte_err
);
  logic [15:0] lowc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lowc <= '0;
    else if (!prog_n) lowc <= lowc + 1'b1;
    else              lowc <= '0;
  end

  assert_strobe_prep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_n) |-> (vpp_en && data_oe && mode_sel == 5'b01111));

  assert_vpp_after_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_en) |-> (data_oe && mode_sel == 5'b01111 && $stable(prg_addr)));

  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n) |-> (lowc == 16'(PULSE_CYC)));

  assert_bus_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 5'b00011) |-> !data_oe);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (prog_n && !vpp_en && !data_oe));

  assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_err |-> byte_done);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);

  assert_strobe_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_n) |-> !in_ready);
endmodule

bind byte_prog_seq byte_prog_seq_chk #(.AW(AW), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .prog_n(prog_n),
  .vpp_en(vpp_en), .data_oe(data_oe), .mode_sel(mode_sel),
  .prg_addr(prg_addr), .byte_done(byte_done), .byte_err(byte_err)
);

// File: tb/byte_prog_seq_tb.sv
module byte_prog_seq_tb;
  localparam int AW = 15, SU = 2, PW = 26, HD = 2, ST = 2, TO = 7000;
  localparam logic [4:0] WR = 5'b01111, RD = 5'b00011;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [7:0] in_data = '0;
  logic cfg_use_poll = 0, cfg_verify = 0;
  logic [AW-1:0] prg_addr, err_addr;
  logic [7:0] data_out, data_in;
  logic data_oe, vpp_en, prog_n, rdy_busy, byte_done, byte_err;
  logic [4:0] mode_sel;
  logic [1:0] err_code;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  byte_prog_seq #(.AW(AW), .SETUP_CYC(SU), .PULSE_CYC(PW), .HOLD_CYC(HD),
                  .SETTLE_CYC(ST), .TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .cfg_use_poll(cfg_use_poll),
    .cfg_verify(cfg_verify), .prg_addr(prg_addr), .data_out(data_out),
    .data_oe(data_oe), .data_in(data_in), .mode_sel(mode_sel), .vpp_en(vpp_en),
    .prog_n(prog_n), .rdy_busy(rdy_busy), .byte_done(byte_done),
    .byte_err(byte_err), .err_code(err_code), .err_addr(err_addr));

  // target model
  int busy_len = 20, busy_cnt = 0;
  bit rb_stuck_low = 0, data_lie = 0;
  logic [7:0] corrupt = 8'h00, wd = 8'h00;
  logic pn_d = 1;
  always @(posedge clk) begin
    pn_d <= prog_n;
    if (prog_n && !pn_d && mode_sel == WR && vpp_en && data_oe) begin
      wd <= data_out;
      busy_cnt <= busy_len;
    end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end
  assign rdy_busy = !rb_stuck_low && (busy_cnt == 0);
  assign data_in = (mode_sel == RD && !data_oe) ?
                   ((busy_cnt > 0 && !data_lie) ? {~wd[7], wd[6:0]} : (wd ^ corrupt)) : 8'h00;

  // pin monitor
  int lowc = 0, last_w = 0, strobes = 0, vpp_pre = 0, oe_pre = 0, bad_prep = 0, bad_bus = 0;
  int vpp_run = 0, oe_run = 0, bad_done = 0;
  logic [AW-1:0] strobe_addr;
  logic [7:0] strobe_data;
  always @(negedge clk) if (rst_n) begin
    if (mode_sel == RD && data_oe) bad_bus++;
    if (byte_err && !byte_done) bad_done++;
    if (data_oe && !vpp_en) oe_run++;
    if (vpp_en && prog_n && lowc == 0) vpp_run++;
    if (!prog_n) begin
      if (lowc == 0) begin
        vpp_pre = vpp_run; oe_pre = oe_run;
        strobe_addr = prg_addr; strobe_data = data_out;
        if (!(vpp_en && data_oe && mode_sel == WR)) bad_prep++;
      end
      lowc++;
    end else if (lowc != 0) begin
      last_w = lowc; strobes++; lowc = 0;
    end
    if (in_ready) begin vpp_run = 0; oe_run = 0; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit ready_mid;
  task automatic send(input logic [AW-1:0] a, input logic [7:0] d, input bit pl,
                      input bit vf, input bit flip, output int n);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_addr = a; in_data = d; cfg_use_poll = pl; cfg_verify = vf; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    ready_mid = in_ready;
    if (flip) begin cfg_use_poll = ~pl; cfg_verify = ~vf; end
    n = 0;
    while (n < 20000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (byte_done) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready && prog_n && !vpp_en && !data_oe && !byte_done, "R1 idle pins",
        {in_ready, prog_n, vpp_en, data_oe, byte_done}, 5'b11000);
    chk(mode_sel == RD, "R4 idle mode", mode_sel, RD);
  endtask

  task automatic t_rdybusy_basic();
    int n;
    int s0 = strobes;
    rb_stuck_low = 0; data_lie = 0; corrupt = 0; busy_len = 30;
    send(15'h1234, 8'hA5, 0, 0, 0, n);
    chk(byte_done && !byte_err, "R5 rdy/busy completes", {byte_done, byte_err}, 2'b10);
    chk(!ready_mid, "R11 not ready mid-byte", ready_mid, 0);
    chk(last_w == PW, "R3 strobe width", last_w, PW);
    chk(strobes == s0 + 1, "R3 one strobe per byte", strobes - s0, 1);
    chk(vpp_pre == SU, "R2 vpp lead", vpp_pre, SU);
    chk(oe_pre == SU, "R2 data setup lead", oe_pre, SU);
    chk(bad_prep == 0, "R4 write mode at strobe", bad_prep, 0);
    chk(strobe_addr == 15'h1234 && strobe_data == 8'hA5, "R2 addr/data at strobe",
        {strobe_addr, strobe_data}, {15'h1234, 8'hA5});
    chk(n >= 2*SU + PW + busy_len, "R5 waits for busy", n, 2*SU + PW + busy_len);
  endtask

  task automatic t_rb_ignores_data();
    int n;
    rb_stuck_low = 0; data_lie = 1; busy_len = 400;
    send(15'h0042, 8'h3C, 0, 0, 0, n);
    chk(!byte_err && n >= 2*SU + PW + 400, "R5 data ignored in pin mode", n, 2*SU + PW + 400);
    data_lie = 0;
  endtask

  task automatic t_poll_ignores_pin();
    int n;
    rb_stuck_low = 1; busy_len = 40;
    send(15'h7FFF, 8'h81, 1, 0, 0, n);
    chk(byte_done && !byte_err, "R6 poll completes with pin stuck busy", byte_err, 0);
    chk(n >= 2*SU + PW + 40 && n < 2*SU + PW + HD + 60, "R6 poll latency", n, 2*SU + PW + 40);
    rb_stuck_low = 0;
  endtask

  task automatic t_timeout();
    int n;
    rb_stuck_low = 1; busy_len = 10;
    send(15'h0555, 8'h11, 0, 1, 0, n);
    chk(byte_err && err_code == 2'b01, "R7 timeout code", err_code, 2'b01);
    chk(err_addr == 15'h0555, "R7 timeout addr", err_addr, 15'h0555);
    chk(n == 2*SU + PW + HD + TO, "R7 timeout cycle", n, 2*SU + PW + HD + TO);
    rb_stuck_low = 0;
  endtask

  task automatic t_cfg_latched();
    int n;
    rb_stuck_low = 1; busy_len = 10;
    send(15'h0666, 8'h22, 0, 0, 1, n);
    chk(byte_err && err_code == 2'b01, "R10 mid-byte cfg change ignored", err_code, 2'b01);
    rb_stuck_low = 0;
  endtask

  task automatic t_verify();
    int n;
    busy_len = 25; corrupt = 8'h01;
    send(15'h0ABC, 8'hF0, 1, 1, 0, n);
    chk(byte_err && err_code == 2'b10, "R8 mismatch code", err_code, 2'b10);
    chk(err_addr == 15'h0ABC, "R8 mismatch addr", err_addr, 15'h0ABC);
    corrupt = 8'h00;
    send(15'h0ABD, 8'h0F, 0, 1, 0, n);
    chk(byte_done && !byte_err && err_code == 2'b00, "R8 verify pass", err_code, 2'b00);
  endtask

  task automatic t_stream();
    int n;
    int s0 = strobes;
    busy_len = 12;
    for (int i = 0; i < 5; i++) begin
      send(AW'(i * 3), 8'(8'h40 + i), i[0], i[1], 0, n);
      chk(!byte_err, "R11 stream byte ok", byte_err, 0);
    end
    chk(strobes == s0 + 5, "R3 strobe count", strobes - s0, 5);
    chk(bad_bus == 0, "R9 bus released in read mode", bad_bus, 0);
    chk(bad_done == 0, "R11 err only with done", bad_done, 0);
  endtask

  initial begin
    #(8 * 190000);
    fails++; tests++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rdybusy_basic();
    t_rb_ignores_data();
    t_poll_ignores_pin();
    t_timeout();
    t_cfg_latched();
    t_verify();
    t_stream();
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule